// File: doc/BRIEF.md
# Programmable phased start-up sequencer

This controller brings a device out of configuration and into normal operation. After configuration data has loaded, a single-cycle start pulse launches an eight-step phase walk (phases 0 to 7). Phase 0 is the idle phase before the pulse. Three global events are each tied to a phase that a setting input selects, anywhere from 1 to 6: releasing the open-drain DONE line, dropping the global 3-state control (which lets the user I/O drive), and raising the global write enable (which lets RAMs and flip-flops change state). Phase 7 is fixed. It raises the end-of-start-up flag and leaves the controller in a terminal state until reset.

Progress does not follow a plain counter. Once the DONE phase is reached, the walk stalls there until the synchronised DONE pad reads high. Several devices share that wired-AND line, so any one of them can hold the others back. Two optional waits, one on a clock-lock input and one on an impedance-match input, can also freeze the walk at a selectable hold phase. That keeps later events from firing before those conditions are met. All three asynchronous inputs pass through two-flop synchronisers.

The state machine has five states. S_IDLE is phase 0 and waits for the start pulse. S_RUN advances one phase per cycle. S_HOLD waits for the lock and match conditions. S_PADWAIT waits for the DONE pad to read high. S_END is the terminal state at phase 7. The transitions are:
- S_IDLE to S_RUN on start, entering phase 1.
- S_RUN to S_HOLD at the hold phase while an enabled wait is unmet.
- S_HOLD back to S_RUN once the waits are met. The phase does not change on this transition.
- S_RUN to S_PADWAIT at the DONE phase while the pad reads low.
- S_PADWAIT to S_RUN or S_END when the pad reads high, advancing the phase.
- S_RUN to S_END on leaving phase 6.
- S_END stays in S_END.

Top module: `startup_seq`

## Requirements
- R1: In reset and in idle, phase_o is 0. A start_i pulse in idle moves phase_o to 1. From then on, phase_o changes by exactly +1 whenever it changes, and it ends at 7.
- R2: With phase settings in 1..6, the outputs follow phase_o as follows: done_released_o is 1 exactly when phase_o >= done_phase_i, gts_o is 0 exactly when phase_o >= gts_phase_i, and gwe_o is 1 exactly when phase_o >= gwe_phase_i.
- R3: A phase setting of 0 or 7 selects the default phase for that input: DONE 4, 3-state 5, write enable 6, hold 3.
- R4: eos_o is 1 exactly when phase_o is 7, and every run reaches it.
- R5: While the DONE pad is held low, phase_o never passes the DONE phase.
- R6: done_drive_low_o is the inverse of done_released_o. A value of 1 means the block pulls the pad low.
- R7: done_released_o reads 1 while the external pad is still held low.
- R8: With lock_wait_en_i (or match_wait_en_i) set, phase_o stays at or below the hold phase while lock_i (or match_i) is low. With the enable cleared, that input has no effect.
- R9: Once changed, done_released_o, gts_o and gwe_o keep their new values until reset.
- R10: phase_o passes the DONE phase no earlier than 3 cycles after the last cycle in which the pad read low (two-flop synchroniser plus the state register).
- R11: After eos_o rises, start_i is ignored and all outputs stay constant until reset.
- R12: Reset gives phase_o = 0, gts_o = 1, gwe_o = 0, eos_o = 0, done_drive_low_o = 1. This holds when reset is asserted in the middle of a run too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| start_i | input | 1 | Start pulse; accepted only in idle |
| done_phase_i | input | 3 | Phase that releases DONE (1..6) |
| gts_phase_i | input | 3 | Phase that drops the 3-state control (1..6) |
| gwe_phase_i | input | 3 | Phase that raises the write enable (1..6) |
| hold_phase_i | input | 3 | Phase where the lock and match waits apply (1..6) |
| lock_wait_en_i | input | 1 | Enable the wait for lock_i |
| match_wait_en_i | input | 1 | Enable the wait for match_i |
| lock_i | input | 1 | Asynchronous clock-lock indication |
| match_i | input | 1 | Asynchronous impedance-match indication |
| done_pad_i | input | 1 | Readback of the wired-AND DONE pad |
| done_drive_low_o | output | 1 | 1 = pull the DONE pad low |
| done_released_o | output | 1 | Release status of DONE |
| gts_o | output | 1 | Global 3-state; 1 disables user I/O drivers |
| gwe_o | output | 1 | Global write enable |
| eos_o | output | 1 | End of start-up |
| phase_o | output | 3 | Current phase |

## Verification
Every event output is derived from the phase register, so a wrong state shows up at the ports in the same cycle as a mismatch between phase_o and the event outputs, or as a phase that jumps or stalls. A stall that ignores the DONE pad or an enabled wait shows up as phase_o passing the DONE phase or the hold phase while the corresponding input is still low. A stall that fails to release shows up as a run that never reaches phase 7. A synchroniser that is too short shows up as an advance fewer than 3 cycles after the pad last read low.

// File: rtl/startup_seq_pkg.sv
package startup_seq_pkg;

    localparam int PHASE_W = 3;
    typedef logic [PHASE_W-1:0] phase_t;

    localparam int FIRST_EVENT_PHASE = 1;
    localparam int LAST_EVENT_PHASE  = 6;
    localparam phase_t FINAL_PHASE   = phase_t'(7);

    // selector slots: 0 DONE release, 1 3-state drop, 2 write enable, 3 hold
    localparam int NUM_SEL  = 4;
    localparam int SEL_DONE = 0;
    localparam int SEL_GTS  = 1;
    localparam int SEL_GWE  = 2;
    localparam int SEL_HOLD = 3;
    localparam int SEL_DEFAULT [NUM_SEL] = '{4, 5, 6, 3};

    typedef enum logic [2:0] {
        S_IDLE,
        S_RUN,
        S_HOLD,
        S_PADWAIT,
        S_END
    } seq_state_e;

endpackage

// File: rtl/ss_sync.sv
module ss_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [STAGES-1:0][W-1:0] chain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q[0] <= async_i;
            for (int s = 1; s < STAGES; s++) begin
                chain_q[s] <= chain_q[s-1];
            end
        end
    end

    assign sync_o = chain_q[STAGES-1];

endmodule

// File: rtl/ss_phase_sel.sv
module ss_phase_sel #(
    parameter int PW  = 3,
    parameter int LO  = 1,
    parameter int HI  = 6,
    parameter int DEF = 4
) (
    input  logic [PW-1:0] raw_i,
    output logic [PW-1:0] eff_o
);

    localparam logic [PW-1:0] LO_V  = PW'(LO);
    localparam logic [PW-1:0] HI_V  = PW'(HI);
    localparam logic [PW-1:0] DEF_V = PW'(DEF);

    always_comb begin
        if (raw_i >= LO_V && raw_i <= HI_V) begin
            eff_o = raw_i;
        end else begin
            eff_o = DEF_V;
        end
    end

endmodule

// File: rtl/startup_seq.sv
module startup_seq
    import startup_seq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_i,
    input  logic [PHASE_W-1:0] done_phase_i,
    input  logic [PHASE_W-1:0] gts_phase_i,
    input  logic [PHASE_W-1:0] gwe_phase_i,
    input  logic [PHASE_W-1:0] hold_phase_i,
    input  logic               lock_wait_en_i,
    input  logic               match_wait_en_i,
    input  logic               lock_i,
    input  logic               match_i,
    input  logic               done_pad_i,
    output logic               done_drive_low_o,
    output logic               done_released_o,
    output logic               gts_o,
    output logic               gwe_o,
    output logic               eos_o,
    output logic [PHASE_W-1:0] phase_o
);

    localparam int     NUM_ASYNC  = 3;
    localparam phase_t LAST_EV_PH = phase_t'(LAST_EVENT_PHASE);

    // synchronised inputs
    logic [NUM_ASYNC-1:0] async_in;
    logic [NUM_ASYNC-1:0] sync_in;
    logic pad_s, lock_s, match_s;

    assign async_in = {done_pad_i, lock_i, match_i};

    ss_sync #(.W(NUM_ASYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .async_i(async_in),
        .sync_o (sync_in)
    );

    assign {pad_s, lock_s, match_s} = sync_in;

    // phase selection with fallback to defaults
    phase_t sel_raw [NUM_SEL];
    phase_t sel_eff [NUM_SEL];

    assign sel_raw[SEL_DONE] = done_phase_i;
    assign sel_raw[SEL_GTS]  = gts_phase_i;
    assign sel_raw[SEL_GWE]  = gwe_phase_i;
    assign sel_raw[SEL_HOLD] = hold_phase_i;

    for (genvar i = 0; i < NUM_SEL; i++) begin : g_sel
        ss_phase_sel #(
            .PW (PHASE_W),
            .LO (FIRST_EVENT_PHASE),
            .HI (LAST_EVENT_PHASE),
            .DEF(SEL_DEFAULT[i])
        ) u_sel (
            .raw_i(sel_raw[i]),
            .eff_o(sel_eff[i])
        );
    end

    // state machine
    seq_state_e state_q, state_d;
    phase_t     phase_q, phase_d;
    logic       waits_met;

    assign waits_met = (!lock_wait_en_i  || lock_s) &&
                       (!match_wait_en_i || match_s);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            phase_q <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
        end
    end

    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        unique case (state_q)
            S_IDLE: begin
                if (start_i) begin
                    state_d = S_RUN;
                    phase_d = phase_t'(FIRST_EVENT_PHASE);
                end
            end
            S_RUN: begin
                if (phase_q == sel_eff[SEL_HOLD] && !waits_met) begin
                    state_d = S_HOLD;
                end else if (phase_q == sel_eff[SEL_DONE] && !pad_s) begin
                    state_d = S_PADWAIT;
                end else if (phase_q == LAST_EV_PH) begin
                    state_d = S_END;
                    phase_d = FINAL_PHASE;
                end else begin
                    phase_d = phase_q + phase_t'(1);
                end
            end
            S_HOLD: begin
                if (waits_met) begin
                    state_d = S_RUN;
                end
            end
            S_PADWAIT: begin
                if (pad_s) begin
                    if (phase_q == LAST_EV_PH) begin
                        state_d = S_END;
                        phase_d = FINAL_PHASE;
                    end else begin
                        state_d = S_RUN;
                        phase_d = phase_q + phase_t'(1);
                    end
                end
            end
            S_END: begin
                state_d = S_END;
            end
            default: begin
                state_d = S_IDLE;
                phase_d = '0;
            end
        endcase
    end

    // outputs: sticky flags set as a phase is entered
    logic released_q, gts_q, gwe_q, eos_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            released_q <= 1'b0;
            gts_q      <= 1'b1;
            gwe_q      <= 1'b0;
            eos_q      <= 1'b0;
        end else if (phase_d != phase_q) begin
            if (phase_d >= sel_eff[SEL_DONE]) released_q <= 1'b1;
            if (phase_d >= sel_eff[SEL_GTS])  gts_q      <= 1'b0;
            if (phase_d >= sel_eff[SEL_GWE])  gwe_q      <= 1'b1;
            if (state_d == S_END)             eos_q      <= 1'b1;
        end
    end

    assign done_released_o  = released_q;
    assign done_drive_low_o = !released_q;
    assign gts_o            = gts_q;
    assign gwe_o            = gwe_q;
    assign eos_o            = eos_q;
    assign phase_o          = phase_q;

endmodule

// File: rtl/startup_seq_chk.sv
module startup_seq_chk
    import startup_seq_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               start_i,
    input logic [PHASE_W-1:0] done_phase_i,
    input logic [PHASE_W-1:0] gts_phase_i,
    input logic [PHASE_W-1:0] gwe_phase_i,
    input logic [PHASE_W-1:0] hold_phase_i,
    input logic               lock_wait_en_i,
    input logic               match_wait_en_i,
    input logic               lock_i,
    input logic               match_i,
    input logic               done_pad_i,
    input logic               done_drive_low_o,
    input logic               done_released_o,
    input logic               gts_o,
    input logic               gwe_o,
    input logic               eos_o,
    input logic [PHASE_W-1:0] phase_o
);

    a_r1_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o == $past(phase_o)) || (phase_o == $past(phase_o) + 3'd1));

    a_r4_eos_final: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |-> (phase_o == FINAL_PHASE));

    a_r6_open_drain: assert property (@(posedge clk) disable iff (!rst_n)
        done_drive_low_o != done_released_o);

    a_r9_gts_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !gts_o |=> !gts_o);

    a_r9_gwe_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        gwe_o |=> gwe_o);

    a_r9_release_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done_released_o |=> done_released_o);

    a_r11_terminal: assert property (@(posedge clk) disable iff (!rst_n)
        eos_o |=> (eos_o && $stable(phase_o) && $stable(gts_o) &&
                   $stable(gwe_o) && $stable(done_released_o)));

endmodule

bind startup_seq startup_seq_chk u_chk (.*);

// File: tb/startup_seq_bench.sv
module startup_seq_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start_i = 1'b0;
    logic [2:0] done_phase_i = 3'd4;
    logic [2:0] gts_phase_i = 3'd5;
    logic [2:0] gwe_phase_i = 3'd6;
    logic [2:0] hold_phase_i = 3'd3;
    logic       lock_wait_en_i = 1'b0;
    logic       match_wait_en_i = 1'b0;
    logic       lock_i = 1'b0;
    logic       match_i = 1'b0;
    logic       ext_hold = 1'b0;
    logic       done_pad_i;
    logic       done_drive_low_o, done_released_o, gts_o, gwe_o, eos_o;
    logic [2:0] phase_o;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    assign done_pad_i = !done_drive_low_o && !ext_hold;

    startup_seq u_startup_seq (
        .clk             (clk),
        .rst_n           (rst_n),
        .start_i         (start_i),
        .done_phase_i    (done_phase_i),
        .gts_phase_i     (gts_phase_i),
        .gwe_phase_i     (gwe_phase_i),
        .hold_phase_i    (hold_phase_i),
        .lock_wait_en_i  (lock_wait_en_i),
        .match_wait_en_i (match_wait_en_i),
        .lock_i          (lock_i),
        .match_i         (match_i),
        .done_pad_i      (done_pad_i),
        .done_drive_low_o(done_drive_low_o),
        .done_released_o (done_released_o),
        .gts_o           (gts_o),
        .gwe_o           (gwe_o),
        .eos_o           (eos_o),
        .phase_o         (phase_o)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
        end
    endtask

    // d g w h : raw settings; len men : wait enables; lr mr : cycle the
    // lock / match input rises; xh : cycles the pad is held low externally;
    // ed eg ew eh : effective phases the requirements predict
    typedef struct packed {
        int d; int g; int w; int h;
        int len; int men; int lr; int mr; int xh;
        int ed; int eg; int ew; int eh;
    } row_t;

    localparam int NROWS = 8;
    localparam row_t TBL [NROWS] = '{
        '{4, 5, 6, 3, 0, 0, 200, 200, 0,  4, 5, 6, 3},
        '{1, 2, 3, 3, 0, 0, 200, 200, 0,  1, 2, 3, 3},
        '{6, 6, 6, 3, 0, 0, 200, 200, 0,  6, 6, 6, 3},
        '{0, 7, 7, 0, 0, 0, 200, 200, 0,  4, 5, 6, 3},
        '{2, 1, 5, 3, 1, 0, 20,  200, 0,  2, 1, 5, 3},
        '{5, 4, 6, 2, 0, 1, 200, 25,  0,  5, 4, 6, 2},
        '{3, 5, 6, 4, 0, 0, 0,   0,   30, 3, 5, 6, 4},
        '{4, 5, 6, 4, 1, 1, 12,  18,  15, 4, 5, 6, 4}
    };

    task automatic do_reset();
        rst_n = 1'b0;
        start_i = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic check_reset_state(input string tag);
        check(phase_o == 3'd0, {tag, " R12 phase"}, phase_o, 0);
        check(gts_o == 1'b1, {tag, " R12 gts"}, gts_o, 1);
        check(gwe_o == 1'b0, {tag, " R12 gwe"}, gwe_o, 0);
        check(eos_o == 1'b0, {tag, " R12 eos"}, eos_o, 0);
        check(done_drive_low_o == 1'b1, {tag, " R12 drive low"}, done_drive_low_o, 1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        do_reset();
        // R12 reset state, R1 idle without start
        check_reset_state("reset");
        repeat (5) @(negedge clk);
        check(phase_o == 3'd0, "R1 idle holds phase 0", phase_o, 0);

        for (int r = 0; r < NROWS; r++) begin
            int cyc;
            int prev;
            int lastlow;
            bit padv;
            done_phase_i    = 3'(TBL[r].d);
            gts_phase_i     = 3'(TBL[r].g);
            gwe_phase_i     = 3'(TBL[r].w);
            hold_phase_i    = 3'(TBL[r].h);
            lock_wait_en_i  = TBL[r].len[0];
            match_wait_en_i = TBL[r].men[0];
            lock_i          = (TBL[r].lr == 0);
            match_i         = (TBL[r].mr == 0);
            ext_hold        = (TBL[r].xh > 0);
            do_reset();
            check_reset_state("row");
            start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
            prev = 0;
            lastlow = -1;
            cyc = 0;
            while (cyc < 300 && !eos_o) begin
                int ph;
                ph = int'(phase_o);
                // R1 step
                check(ph == prev || ph == prev + 1, "R1 step", ph, prev + 1);
                if (cyc == 0) check(ph == 1, "R1 first phase", ph, 1);
                // R2 / R3 event outputs against predicted phases
                check(done_released_o == (ph >= TBL[r].ed), "R2 R3 release", done_released_o, ph >= TBL[r].ed);
                check(gts_o == (ph < TBL[r].eg), "R2 R3 gts", gts_o, ph < TBL[r].eg);
                check(gwe_o == (ph >= TBL[r].ew), "R2 R3 gwe", gwe_o, ph >= TBL[r].ew);
                check(eos_o == (ph == 7), "R4 eos", eos_o, ph == 7);
                check(done_drive_low_o == !done_released_o, "R6 open drain", done_drive_low_o, !done_released_o);
                if (ext_hold) begin
                    check(ph <= TBL[r].ed, "R5 pad hold", ph, TBL[r].ed);
                    if (ph >= TBL[r].ed)
                        check(done_released_o == 1'b1, "R7 release while pad low", done_released_o, 1);
                end
                if (TBL[r].len != 0 && !lock_i)
                    check(ph <= TBL[r].eh, "R8 lock wait", ph, TBL[r].eh);
                if (TBL[r].men != 0 && !match_i)
                    check(ph <= TBL[r].eh, "R8 match wait", ph, TBL[r].eh);
                if (ph > TBL[r].ed)
                    check(cyc - lastlow >= 3, "R10 sync latency", cyc - lastlow, 3);
                // drive inputs for the next cycle
                prev = ph;
                cyc++;
                ext_hold = (cyc < TBL[r].xh);
                lock_i   = (cyc >= TBL[r].lr);
                match_i  = (cyc >= TBL[r].mr);
                padv = !done_drive_low_o && !ext_hold;
                if (!padv) lastlow = cyc;
                @(negedge clk);
            end
            check(eos_o == 1'b1, "R4 run reaches eos", eos_o, 1);
            check(phase_o == 3'd7, "R4 final phase", phase_o, 7);
            check(gts_o == 1'b0 && gwe_o == 1'b1, "R9 final events", {gts_o, gwe_o}, 1);
        end

        // R11: start after eos is ignored, outputs frozen
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        lock_i = 1'b0;
        match_i = 1'b0;
        for (int k = 0; k < 6; k++) begin
            check(phase_o == 3'd7 && eos_o && gwe_o && !gts_o && done_released_o,
                  "R11 terminal stable", phase_o, 7);
            @(negedge clk);
        end

        // R12: reset in the middle of a run
        done_phase_i = 3'd2; gts_phase_i = 3'd3; gwe_phase_i = 3'd4; hold_phase_i = 3'd3;
        lock_wait_en_i = 1'b0; match_wait_en_i = 1'b0; ext_hold = 1'b0;
        do_reset();
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (5) @(negedge clk);
        check(gts_o == 1'b0, "R2 mid-run gts dropped", gts_o, 0);
        rst_n = 1'b0;
        @(negedge clk);
        check_reset_state("mid-run");
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        check(phase_o == 3'd0, "R1 idle after reset", phase_o, 0);

        // R8: wait disabled with input low has no effect
        lock_wait_en_i = 1'b0; lock_i = 1'b0;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        repeat (40) @(negedge clk);
        check(eos_o == 1'b1, "R8 disabled lock wait ignored", eos_o, 1);

        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule